// File: doc/BRIEF.md
# Paged Message-Buffer Access Window

This block lets a host reach a bank of fifteen message buffers, each with eight data bytes, through a single byte-wide data window. A page register picks the buffer and holds a byte index into that buffer's data area. Every read or write of the window lands on the byte the page register points at. In the default mode the index then steps forward by one, so a host can stream a whole buffer through the window without rewriting the page register.

The host side is a plain synchronous register bus with two locations. Address 0 is the page register and address 1 is the data window. The bus has no back-pressure: a strobe present at a rising clock edge is always taken at that edge. Read data is registered. It appears after the edge that took the read strobe and holds until the next accepted read. The page register lays out its fields as follows: bits 7:4 are the buffer number, bit 3 is the step-inhibit bit (0 means step after each access, 1 means hold), and bits 2:0 are the byte index. Buffer contents are undefined after reset.

Top module: `mbuf_window`

## Requirements
- R1: While `rst_n` is low, the page register clears to 0x00 and `rdata` clears to 0x00.
- R2: A write to address 0 loads all eight bits of the page register. A read of address 0 returns the page register's value on `rdata` after that edge.
- R3: A write to address 1 stores `wdata` in byte [bits 2:0] of buffer [bits 7:4]. A later read of address 1 at the same position returns that byte on `rdata` after the read edge.
- R4: When page bit 3 is 0, each accepted window access (read or write at address 1) adds one to the index after the access.
- R5: The index wraps from 7 to 0. Stepping never changes page bits 7:3.
- R6: When page bit 3 is 1, window accesses leave the whole page register unchanged.
- R7: With buffer number 15 selected, a window read returns 0x00 and a window write changes no stored byte. The index still steps as set by bit 3.
- R8: Each buffer keeps its own bytes. A write to one buffer never alters another buffer.
- R9: When `we` and `re` are both high in one cycle, the access is treated as a write only. `rdata` does not change, and the index steps at most once.
- R10: Without an accepted read, `rdata` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 = page register, 1 = data window |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| re | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |

## Verification
The hardest cases to reach from the ports are those where a window access leaves no visible result. Examples are a write to the absent buffer 15, or a cycle carrying both strobes. For these, the stimulus reads the page register back right after the access to show where the index ended up. It then reselects a real buffer and reads the bytes that could have been disturbed. Wrap-around is reached by streaming nine writes into one buffer. The first byte must come back as the ninth value, and the buffer number must be unchanged.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam int BUF_W  = 4;
  localparam int IDX_W  = 3;
  localparam int PAGE_W = BUF_W + 1 + IDX_W;

  localparam logic ADDR_PAGE = 1'b0;
  localparam logic ADDR_WIN  = 1'b1;

  // field positions are decoded by the host: buffer, step inhibit, index
  typedef struct packed {
    logic [BUF_W-1:0] bnum;
    logic             hold;
    logic [IDX_W-1:0] idx;
  } page_t;
endpackage

// File: rtl/mbw_page_reg.sv
module mbw_page_reg
  import mbw_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  page_t load_val,
  input  logic  step,
  output page_t page
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      page <= '0;
    else if (load)
      page <= load_val;
    else if (step && !page.hold)
      page.idx <= page.idx + IDX_W'(1);
  end
endmodule

// File: rtl/mbw_store.sv
module mbw_store
  import mbw_pkg::*;
#(
  parameter int NBUF   = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [BUF_W-1:0]  bsel,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NBYTE = 1 << IDX_W;
  localparam int DEPTH = NBUF * NBYTE;
  localparam int AW    = BUF_W + IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              hit;
  logic [AW-1:0]     waddr;

  assign waddr = {bsel, idx};

  generate
    if (NBUF < (1 << BUF_W)) begin : g_partial
      assign hit = (int'(bsel) < NBUF);
    end else begin : g_full
      assign hit = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr && hit)
      mem[waddr] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (hit)
      rdata = mem[waddr];
  end
endmodule

// File: rtl/mbw_rdmux.sv
module mbw_rdmux
  import mbw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              sel_win,
  input  page_t             page,
  input  logic [DATA_W-1:0] win_byte,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= sel_win ? win_byte : DATA_W'(page);
  end
endmodule

// File: rtl/mbuf_window.sv
module mbuf_window
  import mbw_pkg::*;
#(
  parameter int NBUF   = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata
);
  page_t             page_q;
  logic              win_sel;
  logic              win_acc;
  logic              rd_take;
  logic [DATA_W-1:0] win_byte;

  assign win_sel = (addr == ADDR_WIN);
  assign win_acc = win_sel && (we || re);
  assign rd_take = re && !we;

  mbw_page_reg u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (we && !win_sel),
    .load_val (page_t'(wdata[PAGE_W-1:0])),
    .step     (win_acc),
    .page     (page_q)
  );

  mbw_store #(.NBUF(NBUF), .DATA_W(DATA_W)) u_store (
    .clk   (clk),
    .wr    (we && win_sel),
    .bsel  (page_q.bnum),
    .idx   (page_q.idx),
    .wdata (wdata),
    .rdata (win_byte)
  );

  mbw_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_take),
    .sel_win  (win_sel),
    .page     (page_q),
    .win_byte (win_byte),
    .rdata    (rdata)
  );
endmodule

// File: rtl/mbuf_window_chk.sv
module mbuf_window_chk
  import mbw_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        addr,
  input logic        we,
  input logic        re,
  input logic [7:0]  rdata,
  input page_t       pg
);
  // R1
  rst_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (pg == '0 && rdata == '0));

  // R2
  page_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr && re && !we) |=> (rdata == 8'($past(pg))));

  // R4 R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr && (we || re) && !pg.hold) |=>
      (pg.idx == 3'($past(pg.idx) + 3'd1) && pg.bnum == $past(pg.bnum) && !pg.hold));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr && (we || re) && pg.hold) |=> $stable(pg));

  // R7
  nobuf_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr && re && !we && pg.bnum == 4'd15) |=> (rdata == 8'h00));

  // R9 R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!re || we) |=> $stable(rdata));
endmodule

bind mbuf_window mbuf_window_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .addr  (addr),
  .we    (we),
  .re    (re),
  .rdata (rdata),
  .pg    (page_q)
);

// File: tb/mbuf_window_bench.sv
module mbuf_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       we = 1'b0;
  logic       re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;

  always #4 clk = ~clk;

  mbuf_window u_mbuf_window (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
    .wdata(wdata), .re(re), .rdata(rdata)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pm;
  logic [7:0] bm [15][8];
  logic [7:0] last_rd;
  logic       rd_q = 1'b0;
  logic       done = 1'b0;

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: rdata=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results as the design produces them
  always @(posedge clk) rd_q <= rst_n && re && !we;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL scoreboard: unexpected read rdata=%02h expected=none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic model_step();
    if (!pm[3]) pm[2:0] = pm[2:0] + 3'd1;
  endtask

  task automatic idle();
    @(negedge clk); we = 0; re = 0;
  endtask

  task automatic wr_page(input logic [7:0] v);
    @(negedge clk); addr = 0; we = 1; re = 0; wdata = v;
    pm = v;
  endtask

  task automatic rd_page(input string tag);
    @(negedge clk); addr = 0; we = 0; re = 1;
    exp_q.push_back(pm); tag_q.push_back(tag); last_rd = pm;
  endtask

  task automatic wr_win(input logic [7:0] d);
    @(negedge clk); addr = 1; we = 1; re = 0; wdata = d;
    if (pm[7:4] != 4'd15) bm[pm[7:4]][pm[2:0]] = d;
    model_step();
  endtask

  task automatic rd_win(input string tag);
    logic [7:0] e;
    @(negedge clk); addr = 1; we = 0; re = 1;
    e = (pm[7:4] == 4'd15) ? 8'h00 : bm[pm[7:4]][pm[2:0]];
    exp_q.push_back(e); tag_q.push_back(tag); last_rd = e;
    model_step();
  endtask

  task automatic both_win(input logic [7:0] d);
    @(negedge clk); addr = 1; we = 1; re = 1; wdata = d;
    if (pm[7:4] != 4'd15) bm[pm[7:4]][pm[2:0]] = d;
    model_step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pm = 8'h00;
    repeat (3) @(negedge clk);
    check(rdata, 8'h00, "R1 rdata in reset");
    rst_n = 1;
    rd_page("R1 page after reset"); idle();

    // R3 R4: stream eight bytes into buffer 3, then one more to wrap (R5)
    wr_page(8'h30);
    for (int i = 0; i < 8; i++) wr_win(8'hA0 + 8'(i));
    rd_page("R5 index wrapped, bnum kept");
    wr_win(8'hB0);
    rd_page("R4 index stepped after write");
    wr_page(8'h30);
    for (int i = 0; i < 8; i++) rd_win("R3 R4 buffer 3 readback");
    rd_page("R5 wrap after reads");
    idle();

    // R8: separate buffers
    wr_page(8'hE2); wr_win(8'h55); wr_win(8'h66);
    wr_page(8'h02); wr_win(8'h11); wr_win(8'h22);
    wr_page(8'hE2); rd_win("R8 buffer 14"); rd_win("R8 buffer 14");
    wr_page(8'h02); rd_win("R8 buffer 0"); rd_win("R8 buffer 0");
    wr_page(8'h32); rd_win("R8 buffer 3 untouched");
    idle();

    // R6: hold mode
    wr_page(8'h3D); wr_win(8'h77); wr_win(8'h78);
    rd_page("R6 page unchanged");
    rd_win("R6 same byte"); rd_win("R6 same byte");
    rd_page("R6 page unchanged after reads");
    idle();

    // R7: buffer 15
    wr_page(8'hF4); wr_win(8'h99);
    rd_page("R7 index stepped on buffer 15");
    rd_win("R7 buffer 15 reads zero");
    wr_page(8'hFC); wr_win(8'h98); rd_win("R7 hold, reads zero");
    rd_page("R7 hold on buffer 15");
    for (int b = 0; b < 15; b += 14) begin
      wr_page({4'(b), 4'h4});
      rd_win("R7 real buffers untouched");
    end
    idle();

    // R2: arbitrary page value
    wr_page(8'hAB); rd_page("R2 page readback");
    wr_page(8'h5E); rd_page("R2 page readback");

    // R9: both strobes together
    wr_page(8'h10); rd_page("R9 setup"); idle();
    both_win(8'h5A); idle();
    @(negedge clk); check(rdata, last_rd, "R9 rdata held on write+read");
    rd_page("R9 single step");
    wr_page(8'h10); rd_win("R9 write taken");
    idle();

    // R10: idle cycles
    repeat (5) @(negedge clk);
    check(rdata, last_rd, "R10 rdata held while idle");

    idle(); idle();
    if (exp_q.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard: %0d reads pending expected=0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule